// File: doc/BRIEF.md
# Super I/O Index/Data Configuration Port

This block is the configuration front end of a legacy peripheral controller. Software reaches it through two byte-wide locations. Writing offset 0 selects one of 256 internal byte registers by index. Offset 1 then reads or writes the register that the index selects. The index itself lives in register 0 of the file.

Writes through offset 1 pass a filter before they are stored. Large parts of the index space are read-only. A few registers keep only some of their bits. From the stored bytes the block continuously drives enable signals and 10-bit I/O base addresses for a floppy controller, a parallel port and two serial ports. A single external enable input gates the whole port, so an upstream bridge can hide the configuration window.

Top module: `sio_cfg_port`

## Requirements
- R1: A write to offset 0 (acc_addr=0) stores wdata as the index. A read of offset 0 returns the current index.
- R2: A read of offset 1 (acc_addr=1) returns the register the index selects. When the index is 0x00, it returns 0x00 instead.
- R3: Writes through offset 1 change nothing when the index is in 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB or 0xFD–0xFF.
- R4: Register 0xE2 keeps only bits [4:0].
  - The parallel port is enabled unless bits [1:0] are both 1.
  - Serial 0 is enabled by bit 2 and serial 1 by bit 3.
  - The floppy controller is enabled by bit 4.
- R5: The base registers and their masks are:
  - 0xE3 is masked with 0xFC and gives the floppy base.
  - 0xE6 is stored unmasked and gives the parallel base.
  - 0xE7 and 0xE8 are masked with 0xFE and give the serial 0 and serial 1 bases.
  - Each base is the stored byte shifted left by 2.
- R6: After reset, every register is 0x00 except these:
  - 0xE0=0x3C, 0xE2=0x0F, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE, 0xE8=0xBE.
  - The index is 0.
  - Enables: parallel off, serial 0 and serial 1 on, floppy off.
  - Bases: floppy 0x3F0, parallel 0x378, serial 0 0x3F8, serial 1 0x2F8.
- R7: A write through offset 1 to any writable index that has no mask (for example 0xF0) stores the byte unchanged.
- R8: While port_en is low, writes to either offset change nothing and reads return 0xFF.
- R9: Enables and bases show a data write in the first cycle after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | External enable of the configuration window |
| acc_valid | input | 1 | Byte access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 1 | 0 = index location, 1 = data location |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte (combinational) |
| fdc_en | output | 1 | Floppy controller enable |
| lpt_en | output | 1 | Parallel port enable |
| ser0_en | output | 1 | Serial port 0 enable |
| ser1_en | output | 1 | Serial port 1 enable |
| fdc_base | output | 10 | Floppy I/O base |
| lpt_base | output | 10 | Parallel I/O base |
| ser0_base | output | 10 | Serial 0 I/O base |
| ser1_base | output | 10 | Serial 1 I/O base |

## Verification
The hardest case to reach from the ports is a write that must leave no trace. Examples are a data write to a read-only index, or any write while the window is closed. Nothing at the ports changes, so a broken filter and a correct one look the same unless the bench reads back afterwards. The directed sequences therefore put a known value in place first. Then they attempt the forbidden write and read the same index back through offset 1, after reopening the window where needed. A read-only index is also read to confirm it still holds 0x00.

// File: rtl/sio_cfg_port.sv
module sio_cfg_port #(
  parameter int IDX_W      = 8,
  parameter int DW         = 8,
  parameter int BASE_SHIFT = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       port_en,
  input  logic                       acc_valid,
  input  logic                       acc_write,
  input  logic                       acc_addr,
  input  logic [DW-1:0]              wdata,
  output logic [DW-1:0]              rdata,
  output logic                       fdc_en,
  output logic                       lpt_en,
  output logic                       ser0_en,
  output logic                       ser1_en,
  output logic [DW+BASE_SHIFT-1:0]   fdc_base,
  output logic [DW+BASE_SHIFT-1:0]   lpt_base,
  output logic [DW+BASE_SHIFT-1:0]   ser0_base,
  output logic [DW+BASE_SHIFT-1:0]   ser1_base
);
  localparam int NREG   = 1 << IDX_W;
  localparam int BASE_W = DW + BASE_SHIFT;

  localparam logic [IDX_W-1:0] A_ID   = IDX_W'(8'hE0);
  localparam logic [IDX_W-1:0] A_FSEL = IDX_W'(8'hE2);
  localparam logic [IDX_W-1:0] A_FDC  = IDX_W'(8'hE3);
  localparam logic [IDX_W-1:0] A_LPT  = IDX_W'(8'hE6);
  localparam logic [IDX_W-1:0] A_SER0 = IDX_W'(8'hE7);
  localparam logic [IDX_W-1:0] A_SER1 = IDX_W'(8'hE8);

  logic [DW-1:0]    regs [NREG];
  logic [IDX_W-1:0] idx_q;
  logic             wr_idx, wr_dat;

  function automatic logic [DW-1:0] rst_val(input logic [IDX_W-1:0] a);
    case (a)
      A_ID:    rst_val = DW'(8'h3C);
      A_FSEL:  rst_val = DW'(8'h0F);
      A_FDC:   rst_val = DW'(8'hFC);
      A_LPT:   rst_val = DW'(8'hDE);
      A_SER0:  rst_val = DW'(8'hFE);
      A_SER1:  rst_val = DW'(8'hBE);
      default: rst_val = '0;
    endcase
  endfunction

  function automatic logic is_ro(input logic [IDX_W-1:0] a);
    logic [7:0] b;
    b = 8'(a);
    is_ro = (b <= 8'hDF) || (b == 8'hE4) || (b == 8'hE5) ||
            (b >= 8'hE9 && b <= 8'hED) || (b == 8'hF3) || (b == 8'hF5) ||
            (b == 8'hF7) || (b >= 8'hF9 && b <= 8'hFB) || (b >= 8'hFD);
  endfunction

  function automatic logic [DW-1:0] wmask(input logic [IDX_W-1:0] a);
    case (a)
      A_FSEL:         wmask = DW'(8'h1F);
      A_FDC:          wmask = DW'(8'hFC);
      A_SER0, A_SER1: wmask = DW'(8'hFE);
      default:        wmask = '1;
    endcase
  endfunction

  assign idx_q  = IDX_W'(regs[0]);
  assign wr_idx = acc_valid && acc_write && port_en && !acc_addr;
  assign wr_dat = acc_valid && acc_write && port_en && acc_addr && !is_ro(idx_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= rst_val(IDX_W'(i));
    end else if (wr_idx) begin
      regs[0] <= wdata;
    end else if (wr_dat) begin
      regs[idx_q] <= wdata & wmask(idx_q);
    end
  end

  assign rdata = !port_en       ? '1 :
                 !acc_addr      ? DW'(idx_q) :
                 (idx_q == '0)  ? '0 : regs[idx_q];

  assign lpt_en  = regs[A_FSEL][1:0] != 2'b11;
  assign ser0_en = regs[A_FSEL][2];
  assign ser1_en = regs[A_FSEL][3];
  assign fdc_en  = regs[A_FSEL][4];

  assign fdc_base  = BASE_W'(regs[A_FDC])  << BASE_SHIFT;
  assign lpt_base  = BASE_W'(regs[A_LPT])  << BASE_SHIFT;
  assign ser0_base = BASE_W'(regs[A_SER0]) << BASE_SHIFT;
  assign ser1_base = BASE_W'(regs[A_SER1]) << BASE_SHIFT;
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       port_en,
  input logic       acc_valid,
  input logic       acc_write,
  input logic       acc_addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] idx_q,
  input logic       fdc_en,
  input logic       lpt_en,
  input logic       ser0_en,
  input logic       ser1_en,
  input logic [9:0] fdc_base,
  input logic [9:0] lpt_base,
  input logic [9:0] ser0_base,
  input logic [9:0] ser1_base
);
  logic dwr;
  assign dwr = acc_valid && acc_write && port_en && acc_addr;

  a_r1_index_write: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && port_en && !acc_addr) |=> idx_q == $past(wdata));

  a_r1_index_read: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && !acc_addr) |-> rdata == idx_q);

  a_r2_zero_index: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && acc_addr && idx_q == 8'h00) |-> rdata == 8'h00);

  a_r3_ro_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && (idx_q == 8'hE4 || idx_q == 8'hFF)) |=>
      $stable({fdc_en, lpt_en, ser0_en, ser1_en, fdc_base, lpt_base, ser0_base, ser1_base}));

  a_r4_fsel: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && idx_q == 8'hE2) |=>
      (ser0_en == $past(wdata[2])) && (ser1_en == $past(wdata[3])) &&
      (fdc_en == $past(wdata[4])) && (lpt_en == ($past(wdata[1:0]) != 2'b11)));

  a_r5_fdc_base: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && idx_q == 8'hE3) |=> fdc_base == {$past(wdata[7:2]), 4'b0000});

  a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> $stable(idx_q) &&
      $stable({fdc_en, lpt_en, ser0_en, ser1_en, fdc_base, lpt_base, ser0_base, ser1_base}));

  a_r8_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> rdata == 8'hFF);
endmodule

bind sio_cfg_port sio_cfg_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .acc_valid(acc_valid),
  .acc_write(acc_write), .acc_addr(acc_addr), .wdata(wdata), .rdata(rdata),
  .idx_q(idx_q), .fdc_en(fdc_en), .lpt_en(lpt_en), .ser0_en(ser0_en),
  .ser1_en(ser1_en), .fdc_base(fdc_base), .lpt_base(lpt_base),
  .ser0_base(ser0_base), .ser1_base(ser1_base)
);

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb;
  logic       clk = 0, rst_n = 0, port_en = 0;
  logic       acc_valid = 0, acc_write = 0, acc_addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic       fdc_en, lpt_en, ser0_en, ser1_en;
  logic [9:0] fdc_base, lpt_base, ser0_base, ser1_base;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  sio_cfg_port u_dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_addr(acc_addr), .wdata(wdata), .rdata(rdata),
    .fdc_en(fdc_en), .lpt_en(lpt_en), .ser0_en(ser0_en), .ser1_en(ser1_en),
    .fdc_base(fdc_base), .lpt_base(lpt_base), .ser0_base(ser0_base),
    .ser1_base(ser1_base)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_addr = a; wdata = d;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_addr = a;
    #1 d = rdata;
    @(negedge clk);
    acc_valid = 0;
  endtask

  task automatic rd_reg(input logic [7:0] i, output logic [7:0] d);
    wr(0, i);
    rd(1, d);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(0, d);             chk("R6 index", d, 8'h00);
    rd_reg(8'hE0, d);     chk("R6 reg E0", d, 8'h3C);
    rd_reg(8'hE2, d);     chk("R6 reg E2", d, 8'h0F);
    chk("R6 enables", {fdc_en, lpt_en, ser0_en, ser1_en}, 4'b0011);
    chk("R6 fdc base", fdc_base, 10'h3F0);
    chk("R6 lpt base", lpt_base, 10'h378);
    chk("R6 ser0 base", ser0_base, 10'h3F8);
    chk("R6 ser1 base", ser1_base, 10'h2F8);
    rd_reg(8'h50, d);     chk("R6 other reg", d, 8'h00);
  endtask

  task automatic t_index;
    logic [7:0] d;
    wr(0, 8'hE8); rd(0, d); chk("R1 index readback", d, 8'hE8);
    rd(1, d);             chk("R2 selected reg", d, 8'hBE);
    wr(0, 8'h00); rd(1, d); chk("R2 index zero reads 0", d, 8'h00);
  endtask

  task automatic t_fsel;
    logic [7:0] d;
    wr(0, 8'hE2); wr(1, 8'hFF);
    rd(1, d);             chk("R4 mask 1F", d, 8'h1F);
    chk("R4 enables all but lpt", {fdc_en, lpt_en, ser0_en, ser1_en}, 4'b1011);
    @(negedge clk); acc_valid = 1; acc_write = 1; acc_addr = 1; wdata = 8'h01;
    @(negedge clk); acc_valid = 0; acc_write = 0;
    chk("R9 enables after one edge", {fdc_en, lpt_en, ser0_en, ser1_en}, 4'b0100);
    wr(1, 8'h0A);
    chk("R4 ser1 only, lpt on", {fdc_en, lpt_en, ser0_en, ser1_en}, 4'b0101);
  endtask

  task automatic t_bases;
    logic [7:0] d;
    wr(0, 8'hE3); wr(1, 8'hFF); rd(1, d);
    chk("R5 fdc mask", d, 8'hFC);       chk("R5 fdc base", fdc_base, 10'h3F0);
    wr(1, 8'h7F);                       chk("R5 fdc base 2", fdc_base, 10'h1F0);
    wr(0, 8'hE6); wr(1, 8'h01);         chk("R5 lpt unmasked", lpt_base, 10'h004);
    wr(0, 8'hE7); wr(1, 8'h3F);         chk("R5 ser0 base", ser0_base, 10'h0F8);
    wr(0, 8'hE8); wr(1, 8'h01);         chk("R5 ser1 base", ser1_base, 10'h000);
  endtask

  task automatic t_readonly;
    logic [7:0] d;
    wr(0, 8'hE4); wr(1, 8'h55); rd(1, d); chk("R3 E4 ignored", d, 8'h00);
    wr(0, 8'h10); wr(1, 8'hAA); rd(1, d); chk("R3 low range ignored", d, 8'h00);
    wr(0, 8'hFF); wr(1, 8'h33); rd(1, d); chk("R3 FF ignored", d, 8'h00);
    wr(0, 8'hEB); wr(1, 8'h77); rd(1, d); chk("R3 EB ignored", d, 8'h00);
  endtask

  task automatic t_unlisted;
    logic [7:0] d;
    wr(0, 8'hF0); wr(1, 8'hA5); rd(1, d); chk("R7 F0 stored", d, 8'hA5);
    wr(0, 8'hE1); wr(1, 8'h5A); rd(1, d); chk("R7 E1 stored", d, 8'h5A);
  endtask

  task automatic t_gate;
    logic [7:0] d;
    wr(0, 8'hE6); wr(1, 8'h40);
    port_en = 0;
    wr(1, 8'h99); wr(0, 8'hE7);
    rd(0, d);                   chk("R8 disabled read", d, 8'hFF);
    chk("R8 lpt base kept", lpt_base, 10'h100);
    port_en = 1;
    rd(0, d);                   chk("R8 index kept", d, 8'hE6);
    rd(1, d);                   chk("R8 data kept", d, 8'h40);
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; port_en = 1;
    t_reset;
    t_index;
    t_fsel;
    t_bases;
    t_readonly;
    t_unlisted;
    t_gate;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule